// File: doc/BRIEF.md
# Single-Entry Bufferable Write Buffer

This block sits between a core's load/store path and a memory bus whose address phase uses a valid/ready handshake. It holds at most one outgoing transaction. When a write is marked bufferable and the bus is stalled, the block stores the payload and accepts it upstream at once. The core can then move on while the bus drains the stored copy. Transactions not marked bufferable are never stored. They reach the bus combinationally and complete only when the bus accepts them.

While the entry is occupied, the bus side is driven only from the stored copy. A bufferable request that arrives in the cycle the bus takes the stored copy is loaded in its place, so the entry stays occupied. A request that is not bufferable is held off until the entry has drained. A build-time switch removes buffering completely. The block is then a plain wire-through.

Top module: `wr_hold_buf`

## Requirements
- R1: While `rst_ni` is low the entry is empty: `dn_valid_o` equals `up_valid_i`, `dn_txn_o` equals `up_txn_i`, and `up_ready_o` equals `dn_ready_i` for a non-bufferable request.
- R2: When the entry is empty and a valid bufferable request meets `dn_ready_i` low, the payload is stored at the clock edge and the entry becomes occupied.
- R3: When the entry is occupied, `dn_ready_i` is high and a valid bufferable request is present, the stored copy drains and the new payload is stored in the same edge, so the entry stays occupied.
- R4: The stored payload is unchanged in every cycle in which neither the R2 nor the R3 load condition holds.
- R5: `up_ready_o` is high only when the entry is empty, or when it is occupied and `dn_ready_i` is high.
- R6: For a bufferable request (with buffering enabled), `up_ready_o` is low only when the entry is occupied and `dn_ready_i` is low.
- R7: When occupied, `dn_txn_o` equals the stored payload. When empty, `dn_txn_o` equals `up_txn_i` in the same cycle.
- R8: Once `dn_valid_o` is high and `dn_ready_i` is low, the next cycle still has `dn_valid_o` high with `dn_txn_o` unchanged, as long as the upstream side holds its own request.
- R9: With parameter `BUF_EN` = 0 the entry is never occupied: `dn_valid_o`, `dn_txn_o` follow the upstream inputs and `up_ready_o` equals `dn_ready_i`.
- R10: When occupied, `dn_ready_i` high and no valid bufferable request present, the entry becomes empty after the edge.
- R11: A non-bufferable request sees `up_ready_o` low while the entry is occupied. After the entry drains, the request is passed through unstored. The bus receives transactions in the order the upstream side handed them over.
- R12: `dn_valid_o` is high whenever the entry is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_valid_i | input | 1 | Upstream request valid |
| up_txn_i | input | TXN_W | Upstream transaction payload |
| up_bufable_i | input | 1 | Request may be buffered |
| up_ready_o | output | 1 | Upstream request accepted |
| dn_valid_o | output | 1 | Bus request valid |
| dn_txn_o | output | TXN_W | Bus transaction payload |
| dn_ready_i | input | 1 | Bus accepts request |

## Verification
All outputs are combinational functions of the current inputs and the one-bit occupancy state. The bench therefore drives inputs on the falling edge and compares outputs one time unit later, within the same cycle. A load or drain (R2, R3, R10) shows up in the cycle after the rising edge that samples it. The queue-based reference model is advanced only at that rising edge, so its next comparison is the first one that can see the change. Transaction order (R11) is checked when a handshake completes on the bus side. At that point the accepted payload is compared with the oldest payload the model recorded as accepted upstream.

// File: rtl/wr_hold_pkg.sv
package wr_hold_pkg;
  typedef enum logic {
    WH_EMPTY = 1'b0,
    WH_FULL  = 1'b1
  } wh_state_e;
endpackage

// File: rtl/wr_hold_store.sv
module wr_hold_store #(
  parameter int unsigned TXN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TXN_W-1:0] d_i,
  output logic [TXN_W-1:0] q_o
);
  logic [TXN_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/wr_hold_fsm.sv
module wr_hold_fsm
  import wr_hold_pkg::*;
#(
  parameter bit BUF_EN = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      up_valid_i,
  input  logic      up_bufable_i,
  input  logic      dn_ready_i,
  output wh_state_e state_o,
  output logic      load_o,
  output logic      bufe_o
);
  generate
    if (BUF_EN) begin : g_buf
      wh_state_e state_q, state_d;
      logic      req_buf;

      assign req_buf = up_valid_i & up_bufable_i;

      always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
          WH_EMPTY: begin
            if (req_buf && !dn_ready_i) begin
              load_o  = 1'b1;
              state_d = WH_FULL;
            end
          end
          WH_FULL: begin
            if (dn_ready_i) begin
              // drain and refill in one edge when a bufferable request waits
              load_o  = req_buf;
              state_d = req_buf ? WH_FULL : WH_EMPTY;
            end
          end
          default: state_d = WH_EMPTY;
        endcase
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WH_EMPTY;
        else         state_q <= state_d;
      end

      assign state_o = state_q;
      assign bufe_o  = up_bufable_i;
    end else begin : g_pass
      assign state_o = WH_EMPTY;
      assign load_o  = 1'b0;
      assign bufe_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wr_hold_out.sv
module wr_hold_out
  import wr_hold_pkg::*;
#(
  parameter int unsigned TXN_W = 32
) (
  input  wh_state_e        state_i,
  input  logic             bufe_i,
  input  logic             up_valid_i,
  input  logic [TXN_W-1:0] up_txn_i,
  input  logic [TXN_W-1:0] store_i,
  input  logic             dn_ready_i,
  output logic             up_ready_o,
  output logic             dn_valid_o,
  output logic [TXN_W-1:0] dn_txn_o
);
  logic full;
  assign full = (state_i == WH_FULL);

  always_comb begin
    if (full) begin
      dn_valid_o = 1'b1;
      dn_txn_o   = store_i;
      up_ready_o = bufe_i & dn_ready_i;
    end else begin
      dn_valid_o = up_valid_i;
      dn_txn_o   = up_txn_i;
      up_ready_o = bufe_i | dn_ready_i;
    end
  end
endmodule

// File: rtl/wr_hold_buf.sv
module wr_hold_buf
  import wr_hold_pkg::*;
#(
  parameter int unsigned TXN_W  = 32,
  parameter bit          BUF_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_valid_i,
  input  logic [TXN_W-1:0] up_txn_i,
  input  logic             up_bufable_i,
  output logic             up_ready_o,
  output logic             dn_valid_o,
  output logic [TXN_W-1:0] dn_txn_o,
  input  logic             dn_ready_i
);
  wh_state_e        state_q;
  logic             load;
  logic             bufe;
  logic [TXN_W-1:0] store_q;

  wr_hold_fsm #(.BUF_EN(BUF_EN)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .up_valid_i  (up_valid_i),
    .up_bufable_i(up_bufable_i),
    .dn_ready_i  (dn_ready_i),
    .state_o     (state_q),
    .load_o      (load),
    .bufe_o      (bufe)
  );

  wr_hold_store #(.TXN_W(TXN_W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .d_i   (up_txn_i),
    .q_o   (store_q)
  );

  wr_hold_out #(.TXN_W(TXN_W)) u_out (
    .state_i   (state_q),
    .bufe_i    (bufe),
    .up_valid_i(up_valid_i),
    .up_txn_i  (up_txn_i),
    .store_i   (store_q),
    .dn_ready_i(dn_ready_i),
    .up_ready_o(up_ready_o),
    .dn_valid_o(dn_valid_o),
    .dn_txn_o  (dn_txn_o)
  );
endmodule

// File: rtl/wr_hold_buf_chk.sv
module wr_hold_buf_chk
  import wr_hold_pkg::*;
#(
  parameter int unsigned TXN_W  = 32,
  parameter bit          BUF_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_valid_i,
  input logic [TXN_W-1:0] up_txn_i,
  input logic             up_bufable_i,
  input logic             up_ready_o,
  input logic             dn_valid_o,
  input logic [TXN_W-1:0] dn_txn_o,
  input logic             dn_ready_i,
  input wh_state_e        st,
  input logic [TXN_W-1:0] stored
);
  logic bq;
  logic ld_empty, ld_full;
  assign bq       = BUF_EN & up_valid_i & up_bufable_i;
  assign ld_empty = (st == WH_EMPTY) & bq & !dn_ready_i;
  assign ld_full  = (st == WH_FULL) & bq & dn_ready_i;

  AST_LOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_empty |=> (st == WH_FULL) && (stored == $past(up_txn_i))); // R2
  AST_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_full |=> (st == WH_FULL) && (stored == $past(up_txn_i))); // R3
  AST_KEEP_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_empty || ld_full) |=> $stable(stored)); // R4
  AST_READY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ready_o |-> (st == WH_EMPTY) || dn_ready_i); // R5
  AST_READY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BUF_EN && up_bufable_i && !up_ready_o) |-> (st == WH_FULL) && !dn_ready_i); // R6
  AST_OUT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == WH_FULL) |-> dn_txn_o == stored); // R7
  AST_OUT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == WH_EMPTY) |-> (dn_txn_o == up_txn_i) && (dn_valid_o == up_valid_i)); // R7
  AST_DN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == WH_FULL && !dn_ready_i) |=> dn_valid_o && $stable(dn_txn_o)); // R8
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == WH_FULL && dn_ready_i && !bq) |=> st == WH_EMPTY); // R10
  AST_NB_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == WH_FULL && !up_bufable_i) |-> !up_ready_o); // R11
  AST_VALID_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == WH_FULL) |-> dn_valid_o); // R12

  generate
    if (!BUF_EN) begin : g_nobuf
      AST_NEVER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == WH_EMPTY) && (up_ready_o == dn_ready_i)); // R9
    end
  endgenerate
endmodule

bind wr_hold_buf wr_hold_buf_chk #(.TXN_W(TXN_W), .BUF_EN(BUF_EN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .up_valid_i  (up_valid_i),
  .up_txn_i    (up_txn_i),
  .up_bufable_i(up_bufable_i),
  .up_ready_o  (up_ready_o),
  .dn_valid_o  (dn_valid_o),
  .dn_txn_o    (dn_txn_o),
  .dn_ready_i  (dn_ready_i),
  .st          (state_q),
  .stored      (store_q)
);

// File: tb/sim_wr_hold_buf.sv
`timescale 1ns/1ps
module sim_wr_hold_buf;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic         a_vld = 0, a_buf = 0, a_rdy = 0;
  logic [W-1:0] a_txn = '0;
  logic         a_uprdy, a_dvld;
  logic [W-1:0] a_dtxn;

  logic         b_vld = 0, b_buf = 0, b_rdy = 0;
  logic [W-1:0] b_txn = '0;
  logic         b_uprdy, b_dvld;
  logic [W-1:0] b_dtxn;

  wr_hold_buf #(.TXN_W(W), .BUF_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .up_valid_i(a_vld), .up_txn_i(a_txn),
    .up_bufable_i(a_buf), .up_ready_o(a_uprdy), .dn_valid_o(a_dvld),
    .dn_txn_o(a_dtxn), .dn_ready_i(a_rdy));

  wr_hold_buf #(.TXN_W(W), .BUF_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .up_valid_i(b_vld), .up_txn_i(b_txn),
    .up_bufable_i(b_buf), .up_ready_o(b_uprdy), .dn_valid_o(b_dvld),
    .dn_txn_o(b_dtxn), .dn_ready_i(b_rdy));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] q0[$];   // model of the stored entry
  logic [W-1:0] ord[$];  // payloads accepted upstream, not yet on the bus
  logic [W-1:0] seq = 16'h0100;
  bit a_pend = 0, b_pend = 0;
  bit prev_wait = 0;
  logic [W-1:0] prev_txn = '0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic cycle(input int vp, input int bp, input int rp);
    bit full, e_vld, e_rdy, up_acc, dn_acc;
    logic [W-1:0] e_txn, got;
    @(negedge clk);
    if (!a_pend) begin
      a_vld = ($urandom_range(99) < vp);
      a_buf = ($urandom_range(99) < bp);
      a_txn = seq; seq = seq + 1'b1;
      a_pend = a_vld;
    end
    a_rdy = ($urandom_range(99) < rp);
    if (!b_pend) begin
      b_vld = ($urandom_range(99) < vp);
      b_buf = ($urandom_range(99) < bp);
      b_txn = ~seq;
      b_pend = b_vld;
    end
    b_rdy = ($urandom_range(99) < rp);
    #1;
    full  = (q0.size() != 0);
    e_vld = full ? 1'b1 : a_vld;
    e_txn = full ? q0[0] : a_txn;
    e_rdy = full ? (a_buf & a_rdy) : (a_buf | a_rdy);
    chk(a_dvld == e_vld, full ? "R12 R10" : "R7", W'(a_dvld), W'(e_vld));
    chk(a_dtxn == e_txn, full ? "R7 R2 R3 R4" : "R7", a_dtxn, e_txn);
    chk(a_uprdy == e_rdy, full ? (a_buf ? "R5" : "R11") : (a_buf ? "R6" : "R5"), W'(a_uprdy), W'(e_rdy));
    if (prev_wait) chk(a_dvld && a_dtxn == prev_txn, "R8", a_dtxn, prev_txn);
    chk(b_dvld == b_vld && b_dtxn == b_txn && b_uprdy == b_rdy, "R9",
        {b_dvld, b_uprdy, b_dtxn[W-3:0]}, {b_vld, b_rdy, b_txn[W-3:0]});
    prev_wait = e_vld && !a_rdy;
    prev_txn  = a_dtxn;
    up_acc = a_vld && e_rdy;
    dn_acc = e_vld && a_rdy;
    got = a_dtxn;
    @(posedge clk);
    if (up_acc) begin ord.push_back(a_txn); a_pend = 0; end
    if (dn_acc) begin
      if (ord.size() != 0) chk(got == ord[0], "R11", got, ord[0]);
      else chk(1'b0, "R11", got, '0);
      if (ord.size() != 0) void'(ord.pop_front());
    end
    if (full) begin
      if (a_rdy) void'(q0.pop_front());
      if (a_vld && a_buf && a_rdy) q0.push_back(a_txn);
    end else if (a_vld && a_buf && !a_rdy) q0.push_back(a_txn);
    if (b_vld && b_rdy) b_pend = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    a_vld = 0; a_buf = 0; a_rdy = 0; a_pend = 0;
    b_vld = 0; b_pend = 0;
    #1;
    chk(a_dvld == 1'b0, "R1", W'(a_dvld), '0);
    chk(a_dtxn == a_txn, "R1", a_dtxn, a_txn);
    chk(a_uprdy == 1'b0, "R1", W'(a_uprdy), '0);
    a_vld = 1; #1;
    chk(a_dvld == 1'b1, "R1", W'(a_dvld), 1);
    a_vld = 0;
    q0.delete(); ord.delete(); prev_wait = 0;
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", '0, '1);
    finish_run();
  end

  initial begin
    #1;
    chk(a_dvld == 1'b0 && a_uprdy == 1'b0, "R1", {a_dvld, a_uprdy}, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    for (int i = 0; i < 40; i++) cycle(90, 100, 100);  // pass-through, R7
    for (int i = 0; i < 10; i++) cycle(100, 100, 0);   // load then stall, R2 R6 R8
    for (int i = 0; i < 30; i++) cycle(100, 100, 100); // refill, R3
    for (int i = 0; i < 8; i++)  cycle(100, 100, 0);
    do_reset();                                        // R1 while occupied
    for (int i = 0; i < 6; i++)  cycle(100, 100, 0);
    for (int i = 0; i < 40; i++) cycle(100, 0, 50);    // drain then non-bufferable, R10 R11
    for (int i = 0; i < 3000; i++) cycle(60, 50, 50);
    for (int i = 0; i < 500; i++) cycle(100, 80, 30);
    finish_run();
  end
endmodule